// File: doc/BRIEF.md
# Register-Relative Stack Machine Step Core

This core executes a small stack machine, one instruction at a time. The whole architectural state is three address registers: a program pointer, an allocation pointer and a frame pointer. Code and data share a single word-addressed memory held inside the core. Before reset is released, a load port fills that memory with the program and its initial data. Each step fetches the instruction word at the program pointer. It then reads the operands through addresses formed as signed offsets from those registers, computes a result and updates the three registers. Nothing outside the core influences the step.

Only three operations exist. A call saves the caller's frame pointer and return address on the stack. A return restores them. An equality assertion compares a memory cell against the computed result and never writes memory. A failed assertion raises a sticky fault and stops the core. Relative, absolute and conditional jumps come from the program-pointer update flags. The step-done pulse marks each completed step, so a trace can be compared register by register. The halt input keeps the core from starting further steps.

Top module: `vm_step_core`

## Requirements
- R1: While reset is asserted and after it is released, before the first step completes, the program pointer reads PC_INIT (0), the allocation and frame pointers read AP_INIT (64), and both fault and step_done are low.
- R2: An instruction word holds off_dst in bits 15:0, off_op0 in bits 31:16 and off_op1 in bits 47:32, all signed. It holds single-bit flags from bit 48 upward: dst base fp (48), op0 base fp (49), op1 immediate (50), op1 base fp (51), op1 base ap (52), result add (53), result multiply (54), absolute jump (55), relative jump (56), conditional jump (57), ap plus result (58), ap plus one (59), call (60), return (61), assert-equal (62). The dst and op0 addresses are the selected register plus the offset. The op1 address is fp or ap plus off_op1, or pc plus one for an immediate. With no op1 source flag set, it is the op0 value plus off_op1.
- R3: The result is op1 by default, op0 + op1 with the add flag, and op0 * op1 with the multiply flag, truncated to the word width.
- R4: Without a jump, call or return, the program pointer advances by 2 when op1 is immediate and by 1 otherwise.
- R5: An absolute jump loads the program pointer with the result. A relative jump adds the result to it.
- R6: A conditional jump adds op1 to the program pointer when the dst cell is nonzero. When the dst cell is zero, the program pointer advances as in R4.
- R7: The allocation pointer is unchanged by default, gains the result with the ap-plus-result flag, and gains 1 with the ap-plus-one flag.
- R8: A call stores fp at [ap] and the return address (pc + instruction size) at [ap+1]. It then sets both fp and ap to ap + 2 and takes the program pointer from the jump flags.
- R9: A return loads fp from [fp-2] and the program pointer from [fp-1].
- R10: When an assert-equal finds the dst cell different from the result, fault rises and stays high. The three registers keep their pre-step values and no further step completes.
- R11: step_done is a one-cycle pulse per completed step, and the three registers change only in the cycle in which it is high.
- R12: While halt is high, no new step starts, so no step completes and the registers hold their values. Execution continues when halt falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write strobe of the memory load port |
| load_addr | input | ADDR_W | Word address for the load port |
| load_data | input | WORD_W | Word written through the load port |
| halt | input | 1 | Holds the core before the next fetch |
| pc_o | output | ADDR_W | Program pointer |
| ap_o | output | ADDR_W | Allocation pointer |
| fp_o | output | ADDR_W | Frame pointer |
| step_done | output | 1 | One-cycle pulse after each committed step |
| fault | output | 1 | Sticky assertion-failure flag |

## Verification
A wrong pointer value shows up in the register trace at the step_done pulse where the bad update happens, and it cannot hide afterwards. A later relative jump or frame access built on that pointer reads a different cell. The program then either diverges in the trace or trips an assertion fault within a few steps. A corrupted call frame stays invisible until the matching return, which then restores the wrong frame pointer or return address. A failure to freeze on fault or halt is seen directly as an extra step_done pulse or a moving register.

// File: rtl/vm_step_pkg.sv
package vm_step_pkg;

   // Decoded instruction: the field order equals the bit order of the word
   typedef struct packed {
      logic        op_assert;
      logic        op_ret;
      logic        op_call;
      logic        ap_one;
      logic        ap_res;
      logic        pc_jnz;
      logic        pc_rel;
      logic        pc_abs;
      logic        res_mul;
      logic        res_add;
      logic        op1_ap;
      logic        op1_fp;
      logic        op1_imm;
      logic        op0_fp;
      logic        dst_fp;
      logic [15:0] off_op1;
      logic [15:0] off_op0;
      logic [15:0] off_dst;
   } dec_t;

   localparam int INSN_W = $bits(dec_t);

   typedef enum logic [3:0] {
      S_FETCH, S_OP0, S_OP1, S_DST, S_AUX0, S_AUX1, S_EXEC, S_SAVE, S_STOP
   } state_e;

endpackage

// File: rtl/vm_step_mem.sv
module vm_step_mem #(
   parameter  int DEPTH  = 256,
   parameter  int WORD_W = 64,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              ld_en,
   input  logic [AW-1:0]     ld_addr,
   input  logic [WORD_W-1:0] ld_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (ld_en)      cells[ld_addr] <= ld_data;
      else if (wr_en) cells[wr_addr] <= wr_data;
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/vm_step_decode.sv
module vm_step_decode
   import vm_step_pkg::*;
(
   input  logic [INSN_W-1:0] word,
   output dec_t              dec
);
   assign dec = dec_t'(word);
endmodule

// File: rtl/vm_step_agen.sv
module vm_step_agen
   import vm_step_pkg::*;
#(
   parameter int AW = 8
) (
   input  dec_t          dec,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] ap,
   input  logic [AW-1:0] fp,
   input  logic [AW-1:0] op0_ptr,
   output logic [AW-1:0] dst_addr,
   output logic [AW-1:0] op0_addr,
   output logic [AW-1:0] op1_addr
);
   logic [15:0]   raw [3];
   logic [AW-1:0] ext [3];

   assign raw[0] = dec.off_dst;
   assign raw[1] = dec.off_op0;
   assign raw[2] = dec.off_op1;

   for (genvar i = 0; i < 3; i++) begin : g_off
      if (AW > 16) begin : g_wide
         assign ext[i] = {{(AW-16){raw[i][15]}}, raw[i]};
      end else begin : g_narrow
         assign ext[i] = raw[i][AW-1:0];
         if (AW < 16) begin : g_drop
            logic unused_hi;
            assign unused_hi = ^raw[i][15:AW];
         end
      end
   end

   logic unused_flags;
   assign unused_flags = ^{dec.op_assert, dec.op_ret, dec.op_call, dec.ap_one,
                           dec.ap_res, dec.pc_jnz, dec.pc_rel, dec.pc_abs,
                           dec.res_mul, dec.res_add};

   assign dst_addr = (dec.dst_fp ? fp : ap) + ext[0];
   assign op0_addr = (dec.op0_fp ? fp : ap) + ext[1];

   always_comb begin
      if (dec.op1_imm)     op1_addr = pc + AW'(1);
      else if (dec.op1_fp) op1_addr = fp + ext[2];
      else if (dec.op1_ap) op1_addr = ap + ext[2];
      else                 op1_addr = op0_ptr + ext[2];
   end
endmodule

// File: rtl/vm_step_next.sv
module vm_step_next
   import vm_step_pkg::*;
#(
   parameter int AW     = 8,
   parameter int WORD_W = 64
) (
   input  dec_t              dec,
   input  logic [AW-1:0]     pc,
   input  logic [AW-1:0]     ap,
   input  logic [AW-1:0]     fp,
   input  logic [WORD_W-1:0] op0,
   input  logic [WORD_W-1:0] op1,
   input  logic [WORD_W-1:0] dst,
   input  logic [AW-1:0]     saved_fp,
   input  logic [AW-1:0]     saved_pc,
   output logic [AW-1:0]     pc_nx,
   output logic [AW-1:0]     ap_nx,
   output logic [AW-1:0]     fp_nx,
   output logic [AW-1:0]     link_pc,
   output logic              assert_ok
);
   logic [WORD_W-1:0] res;
   logic [AW-1:0]     res_a, size;

   logic unused_off;
   assign unused_off = ^{dec.off_dst, dec.off_op0, dec.off_op1,
                         dec.op1_ap, dec.op1_fp, dec.op0_fp, dec.dst_fp};

   always_comb begin
      if (dec.res_mul)      res = op0 * op1;
      else if (dec.res_add) res = op0 + op1;
      else                  res = op1;
   end

   assign res_a     = res[AW-1:0];
   assign size      = dec.op1_imm ? AW'(2) : AW'(1);
   assign link_pc   = pc + size;
   assign assert_ok = !dec.op_assert || (dst == res);

   always_comb begin
      if (dec.op_ret)      pc_nx = saved_pc;
      else if (dec.pc_abs) pc_nx = res_a;
      else if (dec.pc_rel) pc_nx = pc + res_a;
      else if (dec.pc_jnz) pc_nx = (dst != '0) ? pc + op1[AW-1:0] : link_pc;
      else                 pc_nx = link_pc;

      if (dec.op_call)     ap_nx = ap + AW'(2);
      else if (dec.ap_res) ap_nx = ap + res_a;
      else if (dec.ap_one) ap_nx = ap + AW'(1);
      else                 ap_nx = ap;

      if (dec.op_call)     fp_nx = ap + AW'(2);
      else if (dec.op_ret) fp_nx = saved_fp;
      else                 fp_nx = fp;
   end
endmodule

// File: rtl/vm_step_core.sv
module vm_step_core
   import vm_step_pkg::*;
#(
   parameter  int MEM_DEPTH = 256,
   parameter  int WORD_W    = 64,
   parameter  int PC_INIT   = 0,
   parameter  int AP_INIT   = 64,
   localparam int ADDR_W    = $clog2(MEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [WORD_W-1:0] load_data,
   input  logic              halt,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] ap_o,
   output logic [ADDR_W-1:0] fp_o,
   output logic              step_done,
   output logic              fault
);
   if (WORD_W < INSN_W + 1) begin : g_bad_width
      $error("WORD_W must hold a full instruction word");
   end
   if ((1 << ADDR_W) != MEM_DEPTH) begin : g_bad_depth
      $error("MEM_DEPTH must be a power of two");
   end
   if (PC_INIT >= MEM_DEPTH || AP_INIT >= MEM_DEPTH) begin : g_bad_init
      $error("initial pointers must lie inside memory");
   end

   state_e              state_q;
   logic [INSN_W-1:0]   ir_q;
   logic [WORD_W-1:0]   op0_q, op1_q, dst_q;
   logic [ADDR_W-1:0]   aux0_q, aux1_q;
   logic [ADDR_W-1:0]   pc_q, ap_q, fp_q;
   logic                fault_q, done_q;

   dec_t                dec;
   logic [ADDR_W-1:0]   dst_addr, op0_addr, op1_addr, rd_addr, wr_addr;
   logic [WORD_W-1:0]   rd_data, wr_data;
   logic                wr_en, commit, assert_ok;
   logic [ADDR_W-1:0]   pc_nx, ap_nx, fp_nx, link_pc;

   vm_step_mem #(.DEPTH(MEM_DEPTH), .WORD_W(WORD_W)) i_mem (
      .clk(clk), .ld_en(load_en), .ld_addr(load_addr), .ld_data(load_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data));

   vm_step_decode i_dec (.word(ir_q), .dec(dec));

   vm_step_agen #(.AW(ADDR_W)) i_agen (
      .dec(dec), .pc(pc_q), .ap(ap_q), .fp(fp_q), .op0_ptr(op0_q[ADDR_W-1:0]),
      .dst_addr(dst_addr), .op0_addr(op0_addr), .op1_addr(op1_addr));

   vm_step_next #(.AW(ADDR_W), .WORD_W(WORD_W)) i_next (
      .dec(dec), .pc(pc_q), .ap(ap_q), .fp(fp_q),
      .op0(op0_q), .op1(op1_q), .dst(dst_q),
      .saved_fp(aux0_q), .saved_pc(aux1_q),
      .pc_nx(pc_nx), .ap_nx(ap_nx), .fp_nx(fp_nx),
      .link_pc(link_pc), .assert_ok(assert_ok));

   always_comb begin
      case (state_q)
         S_OP0:   rd_addr = op0_addr;
         S_OP1:   rd_addr = op1_addr;
         S_DST:   rd_addr = dst_addr;
         S_AUX0:  rd_addr = fp_q - ADDR_W'(2);
         S_AUX1:  rd_addr = fp_q - ADDR_W'(1);
         default: rd_addr = pc_q;
      endcase
   end

   // Call frame: caller fp at [ap] in EXEC, return address at [ap+1] in SAVE
   assign wr_en   = (state_q == S_EXEC && dec.op_call && assert_ok) || state_q == S_SAVE;
   assign wr_addr = (state_q == S_SAVE) ? ap_q + ADDR_W'(1) : ap_q;
   assign wr_data = (state_q == S_SAVE) ? WORD_W'(link_pc) : WORD_W'(fp_q);
   assign commit  = (state_q == S_EXEC && !dec.op_call && assert_ok) || state_q == S_SAVE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_FETCH;
         ir_q    <= '0;
         op0_q   <= '0;
         op1_q   <= '0;
         dst_q   <= '0;
         aux0_q  <= '0;
         aux1_q  <= '0;
         pc_q    <= ADDR_W'(PC_INIT);
         ap_q    <= ADDR_W'(AP_INIT);
         fp_q    <= ADDR_W'(AP_INIT);
         fault_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_FETCH: if (!halt) begin
               ir_q    <= rd_data[INSN_W-1:0];
               state_q <= S_OP0;
            end
            S_OP0:  begin op0_q  <= rd_data;               state_q <= S_OP1;  end
            S_OP1:  begin op1_q  <= rd_data;               state_q <= S_DST;  end
            S_DST:  begin dst_q  <= rd_data;               state_q <= S_AUX0; end
            S_AUX0: begin aux0_q <= rd_data[ADDR_W-1:0];   state_q <= S_AUX1; end
            S_AUX1: begin aux1_q <= rd_data[ADDR_W-1:0];   state_q <= S_EXEC; end
            S_EXEC: begin
               if (!assert_ok) begin
                  fault_q <= 1'b1;
                  state_q <= S_STOP;
               end else if (dec.op_call) begin
                  state_q <= S_SAVE;
               end else begin
                  state_q <= S_FETCH;
               end
            end
            S_SAVE:  state_q <= S_FETCH;
            default: state_q <= S_STOP;
         endcase
         if (commit) begin
            pc_q   <= pc_nx;
            ap_q   <= ap_nx;
            fp_q   <= fp_nx;
            done_q <= 1'b1;
         end
      end
   end

   assign pc_o      = pc_q;
   assign ap_o      = ap_q;
   assign fp_o      = fp_q;
   assign step_done = done_q;
   assign fault     = fault_q;
endmodule

// File: rtl/vm_step_core_chk.sv
module vm_step_core_chk
   import vm_step_pkg::*;
#(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          halt,
   input logic [AW-1:0] pc_o,
   input logic [AW-1:0] ap_o,
   input logic [AW-1:0] fp_o,
   input logic          step_done,
   input logic          fault,
   input state_e        state
);
   p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fault);

   p_fault_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !step_done && $stable(pc_o) && $stable(ap_o) && $stable(fp_o));

   p_quiet_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !step_done |-> $stable(pc_o) && $stable(ap_o) && $stable(fp_o));

   p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      step_done |=> !step_done);

   p_halt_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_FETCH && halt) |=> state == S_FETCH && !step_done);
endmodule

bind vm_step_core vm_step_core_chk #(.AW(ADDR_W)) i_vm_step_core_chk (
   .clk(clk), .rst_n(rst_n), .halt(halt), .pc_o(pc_o), .ap_o(ap_o),
   .fp_o(fp_o), .step_done(step_done), .fault(fault), .state(state_q));

// File: tb/test_vm_step_core.sv
`timescale 1ns/1ps
module test_vm_step_core;
   localparam int AW = 8;
   localparam int WW = 64;
   localparam int DEPTH = 256;

   // flag positions relative to bit 48 (R2)
   localparam logic [14:0] DST_FP = 15'd1 << 0,  OP0_FP = 15'd1 << 1,
                           OP1_IMM = 15'd1 << 2, OP1_FP = 15'd1 << 3,
                           OP1_AP = 15'd1 << 4,  RES_ADD = 15'd1 << 5,
                           RES_MUL = 15'd1 << 6, PC_ABS = 15'd1 << 7,
                           PC_REL = 15'd1 << 8,  PC_JNZ = 15'd1 << 9,
                           AP_RES = 15'd1 << 10, AP_ONE = 15'd1 << 11,
                           OP_CALL = 15'd1 << 12, OP_RET = 15'd1 << 13,
                           OP_AEQ = 15'd1 << 14;

   logic          clk = 1'b0;
   logic          rst_n, load_en, halt;
   logic [AW-1:0] load_addr, pc_o, ap_o, fp_o;
   logic [WW-1:0] load_data;
   logic          step_done, fault;

   always #2 clk = ~clk;

   vm_step_core i_vm_step_core (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
      .load_data(load_data), .halt(halt), .pc_o(pc_o), .ap_o(ap_o),
      .fp_o(fp_o), .step_done(step_done), .fault(fault));

   int n_chk = 0, n_fail = 0, steps_seen = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   typedef struct {
      logic [AW-1:0] pc, ap, fp;
      string         req;
   } exp_t;
   exp_t sb[$];

   task automatic push_step(input int pc, input int ap, input int fp, input string req);
      exp_t e;
      e.pc = AW'(pc); e.ap = AW'(ap); e.fp = AW'(fp); e.req = req;
      sb.push_back(e);
   endtask

   function automatic logic [63:0] ins(input int od, input int o0, input int o1,
                                       input logic [14:0] fl);
      logic [15:0] a, b, c;
      a = 16'(od); b = 16'(o0); c = 16'(o1);
      return {1'b0, fl, c, b, a};
   endfunction

   // monitor: pops the scoreboard at each completed step
   logic prev_done = 1'b0;
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && prev_done)
         check(!step_done, "R11 pulse width", 64'(step_done), 0);
      if (rst_n && step_done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R11 unexpected step", 1, 0);
         end else begin
            e = sb.pop_front();
            check(pc_o == e.pc, {e.req, " pc"}, 64'(pc_o), 64'(e.pc));
            check(ap_o == e.ap, {e.req, " ap"}, 64'(ap_o), 64'(e.ap));
            check(fp_o == e.fp, {e.req, " fp"}, 64'(fp_o), 64'(e.fp));
         end
         steps_seen++;
      end
      prev_done = step_done;
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   logic [63:0] img [DEPTH];

   initial begin
      int done_cnt;
      rst_n = 1'b0; halt = 1'b0; load_en = 1'b0; load_addr = '0; load_data = '0;
      for (int a = 0; a < DEPTH; a++) img[a] = '0;
      img[0]  = ins(0, 1, 1, OP_AEQ | OP1_IMM | RES_ADD | AP_ONE);  img[1]  = 5;
      img[2]  = ins(2, 0, 1, OP_AEQ | DST_FP | OP1_FP | RES_MUL);
      img[3]  = ins(0, 0, 1, OP_AEQ | OP1_IMM | AP_RES);            img[4]  = 7;
      img[5]  = ins(7, 6, 1, OP_AEQ | DST_FP | OP0_FP);
      img[6]  = ins(0, 0, 1, PC_REL | OP1_IMM | AP_ONE);            img[7]  = 4;
      img[10] = ins(0, 0, 1, PC_JNZ | OP1_IMM);                     img[11] = 50;
      img[12] = ins(0, 0, 1, PC_JNZ | OP1_IMM | DST_FP);            img[13] = 6;
      img[18] = ins(0, 0, 1, OP_CALL | PC_ABS | OP1_IMM);           img[19] = 40;
      img[40] = ins(0, 0, 0, OP_RET);
      img[20] = ins(0, 0, 1, PC_ABS | OP1_IMM | AP_ONE);            img[21] = 30;
      img[30] = ins(0, 0, 1, OP_AEQ | DST_FP | OP1_IMM);            img[31] = 13;
      img[64] = 12; img[65] = 7; img[66] = 49; img[70] = 80; img[71] = 33; img[81] = 33;

      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk);
         load_en = 1'b1; load_addr = AW'(a); load_data = img[a];
      end
      @(negedge clk);
      load_en = 1'b0;

      // R1 reset state
      check(pc_o == 0,   "R1 pc",        64'(pc_o), 0);
      check(ap_o == 64,  "R1 ap",        64'(ap_o), 64);
      check(fp_o == 64,  "R1 fp",        64'(fp_o), 64);
      check(!fault,      "R1 fault",     64'(fault), 0);
      check(!step_done,  "R1 step_done", 64'(step_done), 0);

      push_step(2,  65, 64, "R3 R4 R7 add with immediate");
      push_step(3,  65, 64, "R3 multiply fp/ap operands");
      push_step(5,  72, 64, "R7 ap plus result");
      push_step(6,  72, 64, "R2 op0-relative op1");
      push_step(10, 73, 64, "R5 relative jump");
      push_step(12, 73, 64, "R6 jnz not taken");
      push_step(18, 73, 64, "R6 jnz taken");
      push_step(40, 75, 75, "R8 call frame");
      push_step(20, 75, 64, "R9 return restores");
      push_step(30, 76, 64, "R5 absolute jump");

      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(pc_o == 0 && ap_o == 64, "R1 after release", 64'(pc_o), 0);

      wait (steps_seen == 10);
      halt = 1'b1;
      done_cnt = 0;
      repeat (40) begin
         @(negedge clk);
         if (step_done) done_cnt++;
      end
      check(done_cnt == 0, "R12 no step while halted", 64'(done_cnt), 0);
      check(pc_o == 30,    "R12 pc held",             64'(pc_o), 30);
      halt = 1'b0;

      repeat (30) @(negedge clk);
      check(fault == 1'b1, "R10 fault raised", 64'(fault), 1);
      check(pc_o == 30,    "R10 pc frozen",    64'(pc_o), 30);
      check(ap_o == 76,    "R10 ap frozen",    64'(ap_o), 76);
      check(fp_o == 64,    "R10 fp frozen",    64'(fp_o), 64);
      done_cnt = 0;
      repeat (20) begin
         @(negedge clk);
         if (step_done) done_cnt++;
      end
      check(fault == 1'b1,  "R10 fault sticky",      64'(fault), 1);
      check(done_cnt == 0,  "R10 no step after fault", 64'(done_cnt), 0);
      check(steps_seen == 10, "R11 step count",      64'(steps_seen), 10);
      check(sb.size() == 0, "R11 scoreboard drained", 64'(sb.size()), 0);
      finish_run();
   end
endmodule